// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine for a multicycle processor that runs a small integer instruction subset: register-register ALU operations, load word, store word, add immediate, branch on equal and jump. The datapath it drives has one memory that holds both instructions and data, and one ALU. The datapath reads the opcode from its instruction register. The block walks through a sequence of steps, and in each step it drives one fixed control vector. That vector sets the memory address source, the memory read and write strobes, the instruction register load, the register file destination and write source, the two ALU operand selectors, the ALU operation class, and the program counter update. An instruction takes three, four or five cycles, depending on its class.

Every instruction starts in `ST_FETCH`, which reads memory at the PC into the instruction register and writes PC+4 back to the PC. It then moves to `ST_DECODE`, where the register operands are read and the branch target is precomputed into the ALU output register. From `ST_DECODE`, the opcode selects the next step:
- load and store go to `ST_ADDR`;
- ALU operations go to `ST_ALU_EXEC`;
- add immediate goes to `ST_IMM_EXEC`;
- branch goes to `ST_BRANCH`;
- jump goes to `ST_JUMP`;
- any other code goes back to `ST_FETCH`.

`ST_ADDR` goes to `ST_STORE_WR` for a store and to `ST_LOAD_RD` for anything else. `ST_LOAD_RD` goes to `ST_LOAD_WB`. `ST_ALU_EXEC` goes to `ST_ALU_WB`, and `ST_IMM_EXEC` goes to `ST_IMM_WB`. The last step of each instruction (`ST_LOAD_WB`, `ST_STORE_WR`, `ST_ALU_WB`, `ST_IMM_WB`, `ST_BRANCH`, `ST_JUMP`) goes back to `ST_FETCH`.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous, active-high `rst` puts the sequencer in the fetch step. Reset can be applied in any step. While `rst` is high, and in the first cycle after it falls, the outputs show the fetch vector.
- R2: The fetch step drives `mem_rd`=1, `addr_sel`=0 (PC addresses memory), `ir_wr`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add), `pc_wr`=1 and `pc_src`=0 (ALU result). In every step, each control not listed for that step is 0.
- R3: The step after fetch is decode. Decode drives `alu_a_sel`=0, `alu_b_sel`=3 (immediate shifted left by 2) and `alu_op`=0, and has no memory, register, IR or PC write. The opcode is sampled at the end of decode.
- R4: Load (opcode 100011) takes 5 cycles. Step 3 computes the address (`alu_a_sel`=1, `alu_b_sel`=2 sign-extended immediate, `alu_op`=0). Step 4 reads memory (`mem_rd`=1, `addr_sel`=1). Step 5 writes back (`rf_wr`=1, `wb_sel`=1 memory data, `dst_sel`=0 rt field).
- R5: Store (opcode 101011) takes 4 cycles. Step 3 computes the address as for a load. Step 4 drives `mem_wr`=1 with `addr_sel`=1.
- R6: An ALU operation (opcode 000000) takes 4 cycles. Step 3 drives `alu_a_sel`=1, `alu_b_sel`=0 (register B) and `alu_op`=2 (funct-driven). Step 4 drives `rf_wr`=1, `dst_sel`=1 (rd field) and `wb_sel`=0 (ALU output).
- R7: Add immediate (opcode 001000) takes 4 cycles. Step 3 drives `alu_a_sel`=1, `alu_b_sel`=2 and `alu_op`=0. Step 4 drives `rf_wr`=1, `dst_sel`=0 and `wb_sel`=0.
- R8: Branch on equal (opcode 000100) takes 3 cycles. Step 3 drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 (subtract), `pc_wr_cond`=1, `pc_src`=1 (ALU output register) and `pc_wr`=0.
- R9: Jump (opcode 000010) takes 3 cycles. Step 3 drives `pc_wr`=1 and `pc_src`=2 (jump address).
- R10: Any other opcode returns to fetch right after decode. Such an instruction takes 2 cycles and writes nothing.
- R11: `mem_rd` and `mem_wr` are never high together. `ir_wr` is high only together with a PC-addressed read. The last step of every instruction is followed by fetch.
- R12: The opcode is used only in decode and, for memory instructions, in the address step. Its value in any other step does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump address |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU output register, 1 memory data register |
| dst_sel | output | 1 | Destination field: 0 rt, 1 rd |
| rf_wr | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 0 register B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 funct-driven |

## Verification
Some properties are checked on every cycle:
- the two memory strobes never overlap;
- the instruction register loads only on a PC-addressed read;
- each fetch is followed by the decode vector;
- a data read is followed by a memory-sourced register write;
- the conditional PC write uses the branch source and subtract;
- every completing step is followed by fetch.

The exact vector in each step, the cycle count for each opcode class, the two-cycle path for unknown opcodes, recovery from reset in the middle of an instruction, and the fact that the opcode is ignored outside decode and the address step can only be shown by the bench's instruction streams.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;
    localparam int OPC_W   = 6;
    localparam int SEL_W   = 2;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_IMM   = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    localparam logic [SEL_W-1:0] BSEL_REG    = 2'd0;
    localparam logic [SEL_W-1:0] BSEL_FOUR   = 2'd1;
    localparam logic [SEL_W-1:0] BSEL_IMM    = 2'd2;
    localparam logic [SEL_W-1:0] BSEL_IMM_SH = 2'd3;

    localparam logic [SEL_W-1:0] AOP_ADD   = 2'd0;
    localparam logic [SEL_W-1:0] AOP_SUB   = 2'd1;
    localparam logic [SEL_W-1:0] AOP_FUNCT = 2'd2;

    localparam logic [SEL_W-1:0] PCS_ALU = 2'd0;
    localparam logic [SEL_W-1:0] PCS_OUT = 2'd1;
    localparam logic [SEL_W-1:0] PCS_JMP = 2'd2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_LOAD_RD, ST_LOAD_WB, ST_STORE_WR,
        ST_ALU_EXEC, ST_ALU_WB, ST_IMM_EXEC, ST_IMM_WB, ST_BRANCH, ST_JUMP
    } step_e;

    typedef enum logic [2:0] {
        CL_ALU, CL_LOAD, CL_STORE, CL_IMM, CL_BRANCH, CL_JUMP, CL_BAD
    } iclass_e;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic [SEL_W-1:0] pc_src;
        logic             addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             wb_sel;
        logic             dst_sel;
        logic             rf_wr;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_op;
    } ctrl_t;
endpackage

// File: rtl/mcyc_op_class.sv
module mcyc_op_class
    import mcyc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          cls
);
    always_comb begin
        unique case (opcode)
            OPC_ALU:   cls = CL_ALU;
            OPC_LOAD:  cls = CL_LOAD;
            OPC_STORE: cls = CL_STORE;
            OPC_IMM:   cls = CL_IMM;
            OPC_BEQ:   cls = CL_BRANCH;
            OPC_JUMP:  cls = CL_JUMP;
            default:   cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output step_e   step
);
    step_e nxt;

    always_ff @(posedge clk) begin
        if (rst) step <= ST_FETCH;
        else     step <= nxt;
    end

    always_comb begin
        unique case (step)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_LOAD, CL_STORE: nxt = ST_ADDR;
                    CL_ALU:            nxt = ST_ALU_EXEC;
                    CL_IMM:            nxt = ST_IMM_EXEC;
                    CL_BRANCH:         nxt = ST_BRANCH;
                    CL_JUMP:           nxt = ST_JUMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:     nxt = (cls == CL_STORE) ? ST_STORE_WR : ST_LOAD_RD;
            ST_LOAD_RD:  nxt = ST_LOAD_WB;
            ST_ALU_EXEC: nxt = ST_ALU_WB;
            ST_IMM_EXEC: nxt = ST_IMM_WB;
            default:     nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl_rom.sv
module mcyc_ctrl_rom
    import mcyc_ctrl_pkg::*;
(
    input  step_e step,
    output ctrl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (step)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = AOP_ADD;
                ctl.pc_wr     = 1'b1;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_IMM_SH;
                ctl.alu_op    = AOP_ADD;
            end
            ST_ADDR, ST_IMM_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = AOP_ADD;
            end
            ST_LOAD_RD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LOAD_WB: begin
                ctl.rf_wr  = 1'b1;
                ctl.wb_sel = 1'b1;
            end
            ST_STORE_WR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_ALU_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_op    = AOP_FUNCT;
            end
            ST_ALU_WB: begin
                ctl.rf_wr   = 1'b1;
                ctl.dst_sel = 1'b1;
            end
            ST_IMM_WB: begin
                ctl.rf_wr = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = BSEL_REG;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCS_OUT;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic [SEL_W-1:0] pc_src,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             wb_sel,
    output logic             dst_sel,
    output logic             rf_wr,
    output logic             alu_a_sel,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [SEL_W-1:0] alu_op
);
    iclass_e cls;
    step_e   step;
    ctrl_t   ctl;

    mcyc_op_class u_class (.opcode(opcode), .cls(cls));
    mcyc_seq      u_seq   (.clk(clk), .rst(rst), .cls(cls), .step(step));
    mcyc_ctrl_rom u_rom   (.step(step), .ctl(ctl));

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_src     = ctl.pc_src;
    assign addr_sel   = ctl.addr_sel;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign wb_sel     = ctl.wb_sel;
    assign dst_sel    = ctl.dst_sel;
    assign rf_wr      = ctl.rf_wr;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign alu_op     = ctl.alu_op;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic [1:0] pc_src,
    input logic       addr_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       wb_sel,
    input logic       dst_sel,
    input logic       rf_wr,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_op
);
    AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_wr && mem_rd && pc_wr && !addr_sel)); // R1

    AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_b_sel == 2'd3 && !ir_wr && !mem_rd && !mem_wr && !rf_wr && !pc_wr)); // R3

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (rf_wr && wb_sel && !dst_sel)); // R4

    AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> addr_sel); // R5

    AST_FUNCT_WRITES_RD: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'd2) |=> (rf_wr && dst_sel && !wb_sel)); // R6

    AST_BRANCH_SOURCE: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (pc_src == 2'd1 && alu_op == 2'd1 && !pc_wr && alu_a_sel)); // R8

    AST_JUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd2) |-> (!mem_rd && !ir_wr && !rf_wr)); // R9

    AST_ONE_MEM_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11

    AST_IR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        ir_wr |-> (mem_rd && !addr_sel)); // R11

    AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (rf_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == 2'd2)) |=> ir_wr); // R11
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (.*);

// File: tb/tb_mcyc_ctrl.sv
`timescale 1ns/1ps
module tb_mcyc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       wb_sel, dst_sel, rf_wr, alu_a_sel;
    logic [1:0] pc_src, alu_b_sel, alu_op;
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;

    localparam logic [5:0] OP_ALU = 6'b000000, OP_LW = 6'b100011, OP_SW = 6'b101011;
    localparam logic [5:0] OP_ADDI = 6'b001000, OP_BEQ = 6'b000100, OP_J = 6'b000010;

    mcyc_ctrl dut (.*);

    always #4 clk = ~clk;

    logic [15:0] act;
    assign act = {pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_wr,
                  wb_sel, dst_sel, rf_wr, alu_a_sel, alu_b_sel, alu_op};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL R1 watchdog: act=%0d cycles exp<50000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] pack(logic pw, logic pc, logic [1:0] ps, logic as, logic mr,
                                         logic mw, logic iw, logic wb, logic ds, logic rw,
                                         logic aa, logic [1:0] bb, logic [1:0] op);
        return {pw, pc, ps, as, mr, mw, iw, wb, ds, rw, aa, bb, op};
    endfunction

    function automatic int steps_of(logic [5:0] op);
        case (op)
            OP_LW:                      return 5;
            OP_SW, OP_ALU, OP_ADDI:     return 4;
            OP_BEQ, OP_J:               return 3;
            default:                    return 2;
        endcase
    endfunction

    // expected vector for step k of instruction op
    function automatic logic [15:0] exp_vec(logic [5:0] op, int k);
        if (k == 0) return pack(1,0,2'd0,0,1,0,1,0,0,0,0,2'd1,2'd0);
        if (k == 1) return pack(0,0,2'd0,0,0,0,0,0,0,0,0,2'd3,2'd0);
        case (op)
            OP_LW: begin
                if (k == 2) return pack(0,0,2'd0,0,0,0,0,0,0,0,1,2'd2,2'd0);
                if (k == 3) return pack(0,0,2'd0,1,1,0,0,0,0,0,0,2'd0,2'd0);
                return pack(0,0,2'd0,0,0,0,0,1,0,1,0,2'd0,2'd0);
            end
            OP_SW: begin
                if (k == 2) return pack(0,0,2'd0,0,0,0,0,0,0,0,1,2'd2,2'd0);
                return pack(0,0,2'd0,1,0,1,0,0,0,0,0,2'd0,2'd0);
            end
            OP_ALU: begin
                if (k == 2) return pack(0,0,2'd0,0,0,0,0,0,0,0,1,2'd0,2'd2);
                return pack(0,0,2'd0,0,0,0,0,0,1,1,0,2'd0,2'd0);
            end
            OP_ADDI: begin
                if (k == 2) return pack(0,0,2'd0,0,0,0,0,0,0,0,1,2'd2,2'd0);
                return pack(0,0,2'd0,0,0,0,0,0,0,1,0,2'd0,2'd0);
            end
            OP_BEQ:  return pack(0,1,2'd1,0,0,0,0,0,0,0,1,2'd0,2'd1);
            OP_J:    return pack(1,0,2'd2,0,0,0,0,0,0,0,0,2'd0,2'd0);
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(logic [5:0] op, int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        case (op)
            OP_LW:   return "R4";
            OP_SW:   return "R5";
            OP_ALU:  return "R6";
            OP_ADDI: return "R7";
            OP_BEQ:  return "R8";
            OP_J:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
        checks = checks + 1;
        if (mem_rd && mem_wr) begin // R11
            fails = fails + 1;
            $display("FAIL R11: act rd=%b wr=%b exp not both", mem_rd, mem_wr);
        end
    endtask

    function automatic logic [5:0] junk();
        return 6'($urandom());
    endfunction

    // positioned at a negedge; runs the first n steps of one instruction
    task automatic run_steps(logic [5:0] op, int n, bit scramble);
        for (int k = 0; k < n; k++) begin
            check(scramble ? "R12" : req_of(op, k), exp_vec(op, k));
            opcode = (k == 1 || k == 2) ? op : (scramble ? junk() : op);
            if (k != n - 1 || n == steps_of(op)) @(negedge clk);
        end
    endtask

    task automatic run_instr(logic [5:0] op, bit scramble);
        run_steps(op, steps_of(op), scramble);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", exp_vec(OP_ALU, 0));
        rst = 1'b0;
        check("R1", exp_vec(OP_ALU, 0));
    endtask

    function automatic logic [5:0] pick_op();
        int r = int'($urandom_range(0, 6));
        logic [5:0] b;
        case (r)
            0: return OP_ALU;
            1: return OP_LW;
            2: return OP_SW;
            3: return OP_ADDI;
            4: return OP_BEQ;
            5: return OP_J;
            default: begin
                b = junk();
                while (b == OP_ALU || b == OP_LW || b == OP_SW || b == OP_ADDI ||
                       b == OP_BEQ || b == OP_J) b = junk();
                return b;
            end
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // directed: each class in turn, including unknown codes at both edges of the space
        run_instr(OP_LW, 0);
        run_instr(OP_SW, 0);
        run_instr(OP_ALU, 0);
        run_instr(OP_ADDI, 0);
        run_instr(OP_BEQ, 0);
        run_instr(OP_J, 0);
        run_instr(6'b111111, 0);
        run_instr(6'b000001, 0);
        run_instr(OP_BEQ, 0);
        // R1: reset in the middle of a load, during the memory read step
        run_steps(OP_LW, 4, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", exp_vec(OP_LW, 0));
        rst = 1'b0;
        run_instr(OP_ALU, 0);
        // R12: random stream with the opcode scrambled outside decode and address steps
        for (int i = 0; i < 400; i++) run_instr(pick_op(), 1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule